// File: doc/BRIEF.md
# Interrupt Controller Register File with Claim and Completion Ports

This block is the memory-mapped register file of a platform interrupt controller. It holds one priority value for each interrupt source, which all targets share. Each target has its own enable bit vector and its own threshold. Each target also has a claim/complete register. The stored configuration goes out on flat vectors to the neighbouring gateway and selection logic, which are separate blocks.

Reading a target's claim/complete register returns the ID that the selection logic currently presents for that target. That ID is the highest-priority enabled pending source, or 0 when there is none. If the ID is not zero, the read also sends a one-cycle claim pulse carrying that ID, so the gateway can clear the source's pending bit. Writing an ID to the same register sends a one-cycle completion pulse carrying that ID, which re-arms the gateway for the source. The controller has no global interrupt disable; a target masks sources only through its enable bits and its threshold.

The bus is a single-cycle port with a byte address, write data, a write strobe and a read strobe. Registers are 32-bit words. The map runs in this order: the priority array, then the enable words, then one threshold/claim pair per target. Read data is registered and appears one cycle after the read strobe.

Top module: `plic_regblock`

## Requirements
- R1: After reset, every priority, enable and threshold reads 0, the `prio_o`, `enable_o` and `thresh_o` vectors are all 0, and no claim or completion pulse is active.
- R2: The priority of source `s` sits at byte address `4*s`. A write keeps only the low `PRIO_W` bits, and a read returns 0 in every higher bit. The slot for the reserved ID 0 always reads 0 and ignores writes.
- R3: The priority written for source `s` appears on `prio_o[s*PRIO_W +: PRIO_W]`, a single copy shared by all targets.
- R4: The enable bit for target `t` and source `s` is bit `s mod 32` of word `NUM_SRC + t*EN_WORDS + s/32`, where `EN_WORDS = ceil(NUM_SRC/32)`. It appears on `enable_o[t*NUM_SRC + s]`. The bit for ID 0 and any bit for a source `s >= NUM_SRC` read 0 and ignore writes.
- R5: The threshold of target `t` sits at word `NUM_SRC + NUM_TGT*EN_WORDS + 2t`. It keeps the low `PRIO_W` bits and appears on `thresh_o[t*PRIO_W +: PRIO_W]`. Writing one target's threshold leaves the other targets' thresholds unchanged.
- R6: A read of target `t`'s claim/complete register, at word `NUM_SRC + NUM_TGT*EN_WORDS + 2t + 1`, returns the ID present on `sel_id_i[t*ID_W +: ID_W]` at the clock edge that samples the read.
- R7: A claim read that returns a non-zero ID raises `claim_o[t]` for exactly one cycle, with `claim_id_o[t*ID_W +: ID_W]` equal to that ID, in the same cycle as the read data. A claim read that returns 0 raises no claim pulse.
- R8: A write of ID `k` with `1 <= k < NUM_SRC` to target `t`'s claim/complete register raises `complete_o[t]` for exactly one cycle, starting the cycle after the write, with `complete_id_o[t*ID_W +: ID_W]` equal to `k`. A write of 0, or of any value of `NUM_SRC` or above, raises no completion pulse.
- R9: A read of an address outside the map, or of an address whose two low bits are not zero, returns 0. A write to such an address changes no register.
- R10: `bus_rdata` is updated one cycle after `bus_re`, and it is 0 in any cycle that follows a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| sel_id_i | input | NUM_TGT*ID_W | Current selected ID for each target, from the selection logic |
| prio_o | output | NUM_SRC*PRIO_W | Priority of each source |
| enable_o | output | NUM_TGT*NUM_SRC | Enable bit of each source for each target |
| thresh_o | output | NUM_TGT*PRIO_W | Threshold of each target |
| claim_o | output | NUM_TGT | One-cycle claim pulse for each target |
| claim_id_o | output | NUM_TGT*ID_W | Claimed ID for each target |
| complete_o | output | NUM_TGT | One-cycle completion pulse for each target |
| complete_id_o | output | NUM_TGT*ID_W | Completed ID for each target |

## Verification
Every result of this block lands exactly one clock edge after the stimulus. This covers read data, the claim pulse that goes with it, the completion pulse after a write, and the configuration vectors after a write. The bench drives each access on a falling edge and removes it on the next falling edge. It samples the results right then, after the single rising edge in between. The pulses get one more sample a cycle later to confirm they drop after one cycle.

// File: rtl/plic_reg_pkg.sv
// Shared types for the interrupt controller register file.
// Assumes: decoded indices fit in 16 bits (sources, words and targets).
package plic_reg_pkg;

    // Register class selected by the address decoder.
    typedef enum logic [2:0] {
        REG_NONE,
        REG_PRIO,
        REG_EN,
        REG_THR,
        REG_CC
    } reg_kind_e;

    // Decoded access: class plus index inside that class.
    typedef struct packed {
        reg_kind_e   kind;
        logic [15:0] idx;
    } reg_sel_t;

endpackage

// File: rtl/plic_reg_decode.sv
// Address decoder for the register file.
// What it does: it turns a byte address into a register class and an index.
//   The index is the source ID for priorities, the flat word number for
//   enables, and the target number for thresholds and claim registers.
// Assumes: word-aligned accesses only. A misaligned or out-of-map address
//   decodes to REG_NONE.
module plic_reg_decode
    import plic_reg_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int NUM_TGT = 2,
    parameter int ADDR_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int EN_WORDS = (NUM_SRC + 31) / 32;
    localparam int EN_BASE  = NUM_SRC;
    localparam int TGT_BASE = EN_BASE + NUM_TGT * EN_WORDS;
    localparam int MAP_END  = TGT_BASE + 2 * NUM_TGT;

    logic [31:0] word;
    logic [31:0] off;

    // Classify the word address into one region of the map.
    always_comb begin
        word     = 32'(addr[ADDR_W-1:2]);
        off      = '0;
        sel.kind = REG_NONE;
        sel.idx  = '0;
        if (addr[1:0] != 2'b00) begin
            sel.kind = REG_NONE;
        end else if (word < 32'(EN_BASE)) begin
            sel.kind = REG_PRIO;
            sel.idx  = 16'(word);
        end else if (word < 32'(TGT_BASE)) begin
            sel.kind = REG_EN;
            sel.idx  = 16'(word - 32'(EN_BASE));
        end else if (word < 32'(MAP_END)) begin
            off      = word - 32'(TGT_BASE);
            sel.kind = off[0] ? REG_CC : REG_THR;
            sel.idx  = 16'(off >> 1);
        end
    end

endmodule

// File: rtl/plic_cfg_store.sv
// Configuration storage: shared priorities, enable words for each target and
// a threshold for each target.
// What it does: it applies bus writes, masks off bits that do not exist, and
//   supplies the read word for these registers.
// Assumes: sel comes from plic_reg_decode, so its index is in range for
//   its class.
module plic_cfg_store
    import plic_reg_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int NUM_TGT = 2,
    parameter int PRIO_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  reg_sel_t                   sel,
    input  logic [31:0]                wdata,
    output logic [31:0]                rd_word,
    output logic [NUM_SRC*PRIO_W-1:0]  prio_flat,
    output logic [NUM_TGT*NUM_SRC-1:0] en_flat,
    output logic [NUM_TGT*PRIO_W-1:0]  thr_flat
);
    localparam int EN_WORDS = (NUM_SRC + 31) / 32;
    localparam int EN_TOTAL = NUM_TGT * EN_WORDS;

    logic [PRIO_W-1:0] prio_q [NUM_SRC];
    logic [31:0]       en_q   [EN_TOTAL];
    logic [PRIO_W-1:0] thr_q  [NUM_TGT];

    // Bits of a flat enable word that map to a real, non-reserved source.
    function automatic logic [31:0] en_mask(input int gw);
        logic [31:0] m;
        int          base;
        base = (gw % EN_WORDS) * 32;
        for (int b = 0; b < 32; b++) begin
            m[b] = (base + b != 0) && (base + b < NUM_SRC);
        end
        return m;
    endfunction

    // Priority registers: slot 0 is reserved and is never written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
        end else if (we && sel.kind == REG_PRIO) begin
            for (int i = 1; i < NUM_SRC; i++) begin
                if (sel.idx == 16'(i)) prio_q[i] <= wdata[PRIO_W-1:0];
            end
        end
    end

    // Enable words: only the bits of existing sources are kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < EN_TOTAL; w++) en_q[w] <= '0;
        end else if (we && sel.kind == REG_EN) begin
            for (int w = 0; w < EN_TOTAL; w++) begin
                if (sel.idx == 16'(w)) en_q[w] <= wdata & en_mask(w);
            end
        end
    end

    // Threshold registers, one for each target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_TGT; t++) thr_q[t] <= '0;
        end else if (we && sel.kind == REG_THR) begin
            for (int t = 0; t < NUM_TGT; t++) begin
                if (sel.idx == 16'(t)) thr_q[t] <= wdata[PRIO_W-1:0];
            end
        end
    end

    // Read multiplexer for the configuration registers.
    always_comb begin
        rd_word = '0;
        case (sel.kind)
            REG_PRIO: for (int i = 0; i < NUM_SRC; i++)
                          if (sel.idx == 16'(i)) rd_word = 32'(prio_q[i]);
            REG_EN:   for (int w = 0; w < EN_TOTAL; w++)
                          if (sel.idx == 16'(w)) rd_word = en_q[w];
            REG_THR:  for (int t = 0; t < NUM_TGT; t++)
                          if (sel.idx == 16'(t)) rd_word = 32'(thr_q[t]);
            default:  rd_word = '0;
        endcase
    end

    // Flatten the stored values onto the output vectors.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
        assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    end
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        assign thr_flat[t*PRIO_W +: PRIO_W] = thr_q[t];
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign en_flat[t*NUM_SRC + s] = en_q[t*EN_WORDS + s/32][s%32];
        end
    end

    // R2/R3: priorities change only on a priority write.
    a_r2_prio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel.kind == REG_PRIO) |=> $stable(prio_flat));
    // R4: enables change only on an enable write.
    a_r4_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel.kind == REG_EN) |=> $stable(en_flat));
    // R5: thresholds change only on a threshold write.
    a_r5_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel.kind == REG_THR) |=> $stable(thr_flat));

endmodule

// File: rtl/plic_cc_port.sv
// Claim/complete port for one target.
// What it does: it turns a claim read into a registered one-cycle claim
//   pulse, and a completion write into a registered one-cycle completion
//   pulse.
// Assumes: rd_hit and wr_hit are already qualified by the bus strobes and
//   the decoded address.
module plic_cc_port #(
    parameter int NUM_SRC = 40,
    parameter int ID_W    = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_hit,
    input  logic            wr_hit,
    input  logic [ID_W-1:0] sel_id,
    input  logic [31:0]     wdata,
    output logic            claim_o,
    output logic [ID_W-1:0] claim_id_o,
    output logic            cmpl_o,
    output logic [ID_W-1:0] cmpl_id_o
);
    logic cmpl_ok;

    // A completion ID is valid if it names a real, non-reserved source.
    always_comb cmpl_ok = (wdata != 32'd0) && (wdata < 32'(NUM_SRC));

    // Claim pulse: raised only when the read returns a non-zero ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claim_o    <= 1'b0;
            claim_id_o <= '0;
        end else begin
            claim_o    <= rd_hit && (sel_id != '0);
            claim_id_o <= (rd_hit && (sel_id != '0)) ? sel_id : '0;
        end
    end

    // Completion pulse: forwarded only for valid IDs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpl_o    <= 1'b0;
            cmpl_id_o <= '0;
        end else begin
            cmpl_o    <= wr_hit && cmpl_ok;
            cmpl_id_o <= (wr_hit && cmpl_ok) ? wdata[ID_W-1:0] : '0;
        end
    end

    // R7: a non-zero claim read yields a claim of that ID on the next cycle.
    a_r7_claim_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && sel_id != '0 |=> claim_o && claim_id_o == $past(sel_id));
    // R7: no claim pulse without a non-zero claim read.
    a_r7_no_spurious_claim: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_hit && sel_id != '0) |=> !claim_o);
    // R8: completion IDs are always in range and non-zero.
    a_r8_cmpl_range: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_o |-> cmpl_id_o != '0 && 32'(cmpl_id_o) < 32'(NUM_SRC));
    // R8: an out-of-range completion write is dropped.
    a_r8_cmpl_drop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && (wdata == 32'd0 || wdata >= 32'(NUM_SRC)) |=> !cmpl_o);

endmodule

// File: rtl/plic_regblock.sv
// Top of the interrupt controller register file.
// What it does: it decodes bus accesses, holds the configuration, registers
//   the read data, and drives the claim and completion pulses of each target.
// Assumes: the selection logic presents the current best ID of each target
//   on sel_id_i; the gateway consumes the claim and completion pulses.
module plic_regblock
    import plic_reg_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int NUM_TGT = 2,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 8,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    input  logic                       bus_we,
    input  logic                       bus_re,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_TGT*ID_W-1:0]    sel_id_i,
    output logic [NUM_SRC*PRIO_W-1:0]  prio_o,
    output logic [NUM_TGT*NUM_SRC-1:0] enable_o,
    output logic [NUM_TGT*PRIO_W-1:0]  thresh_o,
    output logic [NUM_TGT-1:0]         claim_o,
    output logic [NUM_TGT*ID_W-1:0]    claim_id_o,
    output logic [NUM_TGT-1:0]         complete_o,
    output logic [NUM_TGT*ID_W-1:0]    complete_id_o
);
    reg_sel_t    sel;
    logic [31:0] cfg_word;
    logic [31:0] rdata_d;

    plic_reg_decode #(
        .NUM_SRC (NUM_SRC),
        .NUM_TGT (NUM_TGT),
        .ADDR_W  (ADDR_W)
    ) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    plic_cfg_store #(
        .NUM_SRC (NUM_SRC),
        .NUM_TGT (NUM_TGT),
        .PRIO_W  (PRIO_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .sel       (sel),
        .wdata     (bus_wdata),
        .rd_word   (cfg_word),
        .prio_flat (prio_o),
        .en_flat   (enable_o),
        .thr_flat  (thresh_o)
    );

    // One claim/complete port for each target.
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_cc
        logic rd_hit;
        logic wr_hit;
        assign rd_hit = bus_re && sel.kind == REG_CC && sel.idx == 16'(t);
        assign wr_hit = bus_we && sel.kind == REG_CC && sel.idx == 16'(t);

        plic_cc_port #(
            .NUM_SRC (NUM_SRC),
            .ID_W    (ID_W)
        ) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd_hit     (rd_hit),
            .wr_hit     (wr_hit),
            .sel_id     (sel_id_i[t*ID_W +: ID_W]),
            .wdata      (bus_wdata),
            .claim_o    (claim_o[t]),
            .claim_id_o (claim_id_o[t*ID_W +: ID_W]),
            .cmpl_o     (complete_o[t]),
            .cmpl_id_o  (complete_id_o[t*ID_W +: ID_W])
        );
    end

    // Select read data: the live ID for claim registers, the stored word otherwise.
    always_comb begin
        rdata_d = cfg_word;
        if (sel.kind == REG_CC) begin
            rdata_d = '0;
            for (int t = 0; t < NUM_TGT; t++) begin
                if (sel.idx == 16'(t)) rdata_d = 32'(sel_id_i[t*ID_W +: ID_W]);
            end
        end
    end

    // Register the read data; it is zero after a cycle with no read.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= bus_re ? rdata_d : '0;
    end

    // R10: no read strobe gives zero read data on the next cycle.
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> bus_rdata == '0);
    // R9: a read of an unmapped or misaligned address returns zero.
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re && sel.kind == REG_NONE |=> bus_rdata == '0);
    // R7: at most one target claims per access.
    a_r7_single_claim: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_o));

endmodule

// File: tb/plic_regblock_test.sv
// Directed bench for plic_regblock with default parameters
// (40 sources, 2 targets, 3-bit priority, 2 enable words for each target).
module plic_regblock_test;
    localparam int NUM_SRC = 40;
    localparam int NUM_TGT = 2;
    localparam int PRIO_W  = 3;
    localparam int ADDR_W  = 8;
    localparam int ID_W    = 6;

    // Byte addresses derived from the map in the requirements.
    localparam logic [7:0] A_EN_T0W0 = 8'd160;
    localparam logic [7:0] A_EN_T0W1 = 8'd164;
    localparam logic [7:0] A_EN_T1W1 = 8'd172;
    localparam logic [7:0] A_THR0    = 8'd176;
    localparam logic [7:0] A_CC0     = 8'd180;
    localparam logic [7:0] A_THR1    = 8'd184;
    localparam logic [7:0] A_CC1     = 8'd188;
    localparam logic [7:0] A_UNMAP   = 8'd200;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic [ADDR_W-1:0]          bus_addr = '0;
    logic [31:0]                bus_wdata = '0;
    logic                       bus_we = 1'b0;
    logic                       bus_re = 1'b0;
    logic [31:0]                bus_rdata;
    logic [NUM_TGT*ID_W-1:0]    sel_id_i = '0;
    logic [NUM_SRC*PRIO_W-1:0]  prio_o;
    logic [NUM_TGT*NUM_SRC-1:0] enable_o;
    logic [NUM_TGT*PRIO_W-1:0]  thresh_o;
    logic [NUM_TGT-1:0]         claim_o;
    logic [NUM_TGT*ID_W-1:0]    claim_id_o;
    logic [NUM_TGT-1:0]         complete_o;
    logic [NUM_TGT*ID_W-1:0]    complete_id_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    plic_regblock #(
        .NUM_SRC (NUM_SRC),
        .NUM_TGT (NUM_TGT),
        .PRIO_W  (PRIO_W),
        .ADDR_W  (ADDR_W)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_we        (bus_we),
        .bus_re        (bus_re),
        .bus_rdata     (bus_rdata),
        .sel_id_i      (sel_id_i),
        .prio_o        (prio_o),
        .enable_o      (enable_o),
        .thresh_o      (thresh_o),
        .claim_o       (claim_o),
        .claim_id_o    (claim_id_o),
        .complete_o    (complete_o),
        .complete_id_o (complete_id_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Write lasts one cycle; returns on the falling edge after its sampling edge.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    // Read lasts one cycle; data is sampled one edge later.
    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic test_reset();
        logic [31:0] rd;
        chk("R1 prio_o", 32'(prio_o == '0), 32'd1);
        chk("R1 enable_o", 32'(enable_o == '0), 32'd1);
        chk("R1 thresh_o", 32'(thresh_o), 32'd0);
        chk("R1 pulses", 32'({claim_o, complete_o}), 32'd0);
        bus_read(8'd4, rd);  chk("R1 prio1 read", rd, 32'd0);
        bus_read(A_EN_T0W0, rd); chk("R1 enable read", rd, 32'd0);
        bus_read(A_THR1, rd); chk("R1 thresh read", rd, 32'd0);
    endtask

    task automatic test_prio();
        logic [31:0] rd;
        bus_write(8'd20, 32'hFFFF_FFFD);
        bus_read(8'd20, rd);  chk("R2 prio truncation", rd, 32'd5);
        chk("R3 prio_o lane 5", 32'(prio_o[5*PRIO_W +: PRIO_W]), 32'd5);
        bus_write(8'd156, 32'd7);
        chk("R3 prio_o lane 39", 32'(prio_o[39*PRIO_W +: PRIO_W]), 32'd7);
        bus_write(8'd0, 32'd6);
        bus_read(8'd0, rd);   chk("R2 slot 0 reads 0", rd, 32'd0);
        chk("R2 slot 0 lane", 32'(prio_o[0 +: PRIO_W]), 32'd0);
    endtask

    task automatic test_enable();
        logic [31:0] rd;
        bus_write(A_EN_T0W0, 32'hFFFF_FFFF);
        bus_read(A_EN_T0W0, rd); chk("R4 bit for ID 0 masked", rd, 32'hFFFF_FFFE);
        chk("R4 enable_o t0 s0/s1", 32'(enable_o[1:0]), 32'd2);
        bus_write(A_EN_T0W1, 32'hFFFF_FFFF);
        bus_read(A_EN_T0W1, rd); chk("R4 bits beyond last source", rd, 32'h0000_00FF);
        bus_write(A_EN_T1W1, 32'h0000_0008);
        chk("R4 enable_o t1 s35", 32'(enable_o[1*NUM_SRC + 35]), 32'd1);
        chk("R4 t1 word 0 untouched", 32'(enable_o[1*NUM_SRC +: 32]), 32'd0);
    endtask

    task automatic test_thresh();
        logic [31:0] rd;
        bus_write(A_THR1, 32'h1D);
        bus_read(A_THR1, rd); chk("R5 thresh truncation", rd, 32'd5);
        chk("R5 thresh_o t1", 32'(thresh_o[PRIO_W +: PRIO_W]), 32'd5);
        chk("R5 thresh_o t0 kept", 32'(thresh_o[0 +: PRIO_W]), 32'd0);
    endtask

    task automatic test_claim();
        logic [31:0] rd;
        sel_id_i = {6'd0, 6'd9};
        bus_read(A_CC0, rd);
        chk("R6 claim read id", rd, 32'd9);
        chk("R7 claim pulse t0", 32'(claim_o), 32'b01);
        chk("R7 claim id t0", 32'(claim_id_o[0 +: ID_W]), 32'd9);
        @(negedge clk);
        chk("R7 claim one cycle", 32'(claim_o), 32'd0);
        chk("R10 idle rdata zero", bus_rdata, 32'd0);
        bus_read(A_CC1, rd);
        chk("R6 empty claim read", rd, 32'd0);
        chk("R7 no pulse for ID 0", 32'(claim_o), 32'd0);
        sel_id_i = {6'd33, 6'd0};
        bus_read(A_CC1, rd);
        chk("R6 claim read t1", rd, 32'd33);
        chk("R7 claim pulse t1", 32'(claim_o), 32'b10);
        sel_id_i = '0;
    endtask

    task automatic test_complete();
        bus_write(A_CC0, 32'd12);
        chk("R8 complete pulse t0", 32'(complete_o), 32'b01);
        chk("R8 complete id t0", 32'(complete_id_o[0 +: ID_W]), 32'd12);
        @(negedge clk);
        chk("R8 complete one cycle", 32'(complete_o), 32'd0);
        bus_write(A_CC1, 32'd0);
        chk("R8 ID 0 ignored", 32'(complete_o), 32'd0);
        bus_write(A_CC1, 32'd40);
        chk("R8 ID above range ignored", 32'(complete_o), 32'd0);
        bus_write(A_CC1, 32'd39);
        chk("R8 complete pulse t1", 32'(complete_o), 32'b10);
        chk("R8 complete id t1", 32'(complete_id_o[ID_W +: ID_W]), 32'd39);
    endtask

    task automatic test_unmapped();
        logic [31:0] rd;
        logic [NUM_SRC*PRIO_W-1:0]  p0;
        logic [NUM_TGT*NUM_SRC-1:0] e0;
        logic [NUM_TGT*PRIO_W-1:0]  t0;
        p0 = prio_o; e0 = enable_o; t0 = thresh_o;
        bus_write(A_UNMAP, 32'hFFFF_FFFF);
        bus_write(8'd21, 32'h7);
        bus_write(8'd177, 32'h7);
        chk("R9 prio unchanged", 32'(prio_o == p0), 32'd1);
        chk("R9 enable unchanged", 32'(enable_o == e0), 32'd1);
        chk("R9 thresh unchanged", 32'(thresh_o), 32'(t0));
        bus_read(A_UNMAP, rd); chk("R9 unmapped read", rd, 32'd0);
        bus_read(8'd22, rd);   chk("R9 misaligned read", rd, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_prio();
        test_enable();
        test_thresh();
        test_claim();
        test_complete();
        test_unmapped();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule